// File: doc/BRIEF.md
# Compression Metadata Address Translator

This block maps a 48-bit main-surface graphics address to the byte address of the compression control metadata that describes it. The mapping lives in memory as a three-level table tree: two upper levels of 4096 entries each, and a leaf level of 256 entries. Every entry is 64 bits wide. Software loads the byte address of the top table through two 32-bit register writes. After that it presents addresses on a request port. For each level the walker reads one entry over a single-outstanding memory read port. It then returns a one-cycle response that carries the metadata address and the surface attributes held in the leaf entry, or a fault.

Each leaf entry covers a 64 KB block of the main surface and points to a 256-byte metadata block. Every 64-byte cache line of the surface uses 2 metadata bits, which gives one metadata byte per 256 surface bytes. The returned address therefore selects the byte inside that block using address bits [15:8]. The walk copies the table base when it accepts a request, so a rewrite of the base register affects only later requests.

Top module: `meta_xlate_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_rd_req is 0.
- R2: A write to offset 0x4200 loads base bits [31:0], and a write to offset 0x4204 loads base bits [47:32] from data bits [15:0]. Writes to any other offset change nothing. The first read of a walk is at {base[47:15], a[47:36], 3'b000}.
- R3: After a valid top entry T, the next read is at {T[47:15], a[35:24], 3'b000}. Bits [14:1] of T are ignored.
- R4: After a valid middle entry M, the next read is at {M[47:13], 2'b00, a[23:16], 3'b000}. Bits [12:1] of M are ignored.
- R5: For a valid leaf entry L, rsp_meta_addr is {L[47:8], a[15:8]}. Bits [7:4] and [51:48] of L have no effect.
- R6: The leaf fields are returned as follows: rsp_comp_mode = L[2:1], rsp_lossy = L[3], rsp_tile = L[53:52], rsp_depth = L[56:54], rsp_ycr = L[57] and rsp_format = L[63:58].
- R7: An entry with bit 0 clear at any level ends the walk. No further read is issued, and the response has rsp_fault=1 with the address and all attribute outputs at 0. A walk without a fault returns rsp_fault=0.
- R8: mem_rd_req is a one-cycle pulse. No new read is issued until the response to the previous read has arrived, and a successful walk issues exactly three reads.
- R9: A request is taken only while req_ready is 1. req_ready stays 0 from acceptance through the response cycle, and requests presented meanwhile are dropped. rsp_valid lasts exactly one cycle.
- R10: A walk uses the base value held at its acceptance edge, even if the base register is written in the same cycle or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 16 | Register write offset |
| cfg_wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_addr | input | 48 | Main-surface address to translate |
| mem_rd_req | output | 1 | Entry read request pulse |
| mem_rd_addr | output | 48 | Byte address of the entry to read |
| mem_rd_rsp_valid | input | 1 | Entry read data valid |
| mem_rd_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Translation response pulse |
| rsp_fault | output | 1 | An invalid entry was met |
| rsp_meta_addr | output | 48 | Metadata byte address |
| rsp_comp_mode | output | 2 | Compression mode from the leaf |
| rsp_lossy | output | 1 | Lossy flag from the leaf |
| rsp_tile | output | 2 | Tile mode from the leaf |
| rsp_depth | output | 3 | Depth code from the leaf |
| rsp_ycr | output | 1 | YCr flag from the leaf |
| rsp_format | output | 6 | Surface format from the leaf |

## Verification
A wrong level counter or a stale table pointer shows up on the next read address. The fault would appear within one read latency, before any response is produced, so the bench compares every logged fetch address and not just the final result. Corrupt state in the control sequence shows up as a missing or doubled read, a second read while one is pending, or a response pulse longer than one cycle. Each of these is visible on the memory or response port within a cycle or two. A walk that uses the live base register instead of the copy taken at acceptance shows in the first read of that walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W      = 48;
  localparam int ENT_W     = 64;
  localparam int LVLS      = 3;
  localparam int LVL_W     = 2;
  localparam int ENT_SH    = 3;   // log2 of entry size in bytes
  localparam int LEAF_PTR_LO = 8; // leaf pointer alignment (256 B)

  // index field position per level (0 = leaf, LVLS-1 = top)
  function automatic int idx_lo(input int l);
    case (l)
      0:       return 16;
      1:       return 24;
      default: return 36;
    endcase
  endfunction

  function automatic int idx_w(input int l);
    return (l == 0) ? 8 : 12;
  endfunction

  // alignment shift of the table that lives at level l
  function automatic int tbl_sh(input int l);
    return (l == 0) ? 13 : 15;
  endfunction

  typedef struct packed {
    logic [5:0] fmt;
    logic       ycr;
    logic [2:0] depth;
    logic [1:0] tile;
    logic       lossy;
    logic [1:0] comp;
  } leaf_attr_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_t;
endpackage

// File: rtl/xw_base_reg.sv
module xw_base_reg
  import xw_pkg::*;
#(
  parameter int               CFG_AW = 16,
  parameter logic [CFG_AW-1:0] LO_OFS = 16'h4200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [VA_W-1:0]   base_ptr
);
  localparam int HI_W = VA_W - 32;
  localparam logic [CFG_AW-1:0] HI_OFS = LO_OFS + CFG_AW'(4);

  logic [31:0]     lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_en;
  logic            hi_en;
  logic            unused_hi_data;

  assign lo_en = wr_en && (wr_addr == LO_OFS);
  assign hi_en = wr_en && (wr_addr == HI_OFS);
  assign unused_hi_data = ^wr_data[31:HI_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_en) lo_q <= wr_data;
      if (hi_en) hi_q <= wr_data[HI_W-1:0];
    end
  end

  assign base_ptr = {hi_q, lo_q};
endmodule

// File: rtl/xw_fetch_addr.sv
module xw_fetch_addr
  import xw_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  tbl_ptr,
  input  logic [VA_W-1:0]  va,
  output logic [VA_W-1:0]  fetch_addr
);
  localparam int VA_USED_LO = idx_lo(0);

  logic [VA_W-1:0] cand [LVLS];
  logic            unused_va_lo;

  assign unused_va_lo = ^va[VA_USED_LO-1:0];

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    localparam int ILO = idx_lo(g);
    localparam int IW  = idx_w(g);
    localparam int TSH = tbl_sh(g);
    localparam logic [VA_W-1:0] KEEP = {VA_W{1'b1}} << TSH;
    assign cand[g] = (tbl_ptr & KEEP) | (VA_W'(va[ILO +: IW]) << ENT_SH);
  end

  always_comb begin
    fetch_addr = '0;
    for (int l = 0; l < LVLS; l++) begin
      if (lvl == LVL_W'(l)) fetch_addr = cand[l];
    end
  end
endmodule

// File: rtl/xw_leaf_decode.sv
module xw_leaf_decode
  import xw_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [VA_W-1:0]  va,
  output logic [VA_W-1:0]  meta_addr,
  output leaf_attr_t       attr
);
  localparam logic [VA_W-1:0] PTR_KEEP = {VA_W{1'b1}} << LEAF_PTR_LO;

  logic unused_bits;
  assign unused_bits = ^{entry[51:48], entry[7:4], entry[0], va[VA_W-1:16], va[7:0]};

  assign meta_addr  = (entry[VA_W-1:0] & PTR_KEEP) | VA_W'(va[15:8]);
  assign attr.comp  = entry[2:1];
  assign attr.lossy = entry[3];
  assign attr.tile  = entry[53:52];
  assign attr.depth = entry[56:54];
  assign attr.ycr   = entry[57];
  assign attr.fmt   = entry[63:58];
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_addr,
  input  logic [VA_W-1:0]  base_ptr,
  input  logic             ent_valid,
  input  logic [VA_W-1:0]  ent_ptr,
  output logic             req_ready,
  output logic             rd_req,
  output logic             done,
  output logic [LVL_W-1:0] lvl,
  output logic [VA_W-1:0]  tbl_ptr,
  output logic [VA_W-1:0]  va,
  output logic             res_ld,
  output logic             res_fault
);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LVLS - 1);

  walk_st_t         st_q, st_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [VA_W-1:0]  tbl_q, tbl_d;
  logic [VA_W-1:0]  va_q, va_d;
  logic             ctx_en;

  always_comb begin
    st_d      = st_q;
    lvl_d     = lvl_q;
    tbl_d     = tbl_q;
    va_d      = va_q;
    res_ld    = 1'b0;
    res_fault = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d  = ST_ISSUE;
          lvl_d = TOP_LVL;
          tbl_d = base_ptr;
          va_d  = req_addr;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (ent_valid) begin
          if (!ent_ptr[0]) begin
            st_d      = ST_DONE;
            res_ld    = 1'b1;
            res_fault = 1'b1;
          end else if (lvl_q == '0) begin
            st_d   = ST_DONE;
            res_ld = 1'b1;
          end else begin
            st_d  = ST_ISSUE;
            lvl_d = lvl_q - LVL_W'(1);
            tbl_d = ent_ptr;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctx_en = (st_d == ST_ISSUE) && (st_q != ST_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
    end else begin
      st_q <= st_d;
      if (ctx_en) lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ctx_en) begin
      tbl_q <= tbl_d;
      va_q  <= va_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rd_req    = (st_q == ST_ISSUE);
  assign done      = (st_q == ST_DONE);
  assign lvl       = lvl_q;
  assign tbl_ptr   = tbl_q;
  assign va        = va_q;
endmodule

// File: rtl/meta_xlate_walker.sv
module meta_xlate_walker
  import xw_pkg::*;
#(
  parameter int               CFG_AW  = 16,
  parameter logic [CFG_AW-1:0] BASE_OFS = 16'h4200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [31:0]       cfg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  output logic              mem_rd_req,
  output logic [VA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rd_rsp_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [VA_W-1:0]   rsp_meta_addr,
  output logic [1:0]        rsp_comp_mode,
  output logic              rsp_lossy,
  output logic [1:0]        rsp_tile,
  output logic [2:0]        rsp_depth,
  output logic              rsp_ycr,
  output logic [5:0]        rsp_format
);
  logic [VA_W-1:0]  base_ptr;
  logic [LVL_W-1:0] lvl;
  logic [VA_W-1:0]  tbl_ptr;
  logic [VA_W-1:0]  va;
  logic             res_ld;
  logic             res_fault;
  logic [VA_W-1:0]  leaf_meta;
  leaf_attr_t       leaf_attr;

  logic             fault_q;
  logic [VA_W-1:0]  meta_q;
  leaf_attr_t       attr_q;

  xw_base_reg #(.CFG_AW(CFG_AW), .LO_OFS(BASE_OFS)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_wr_addr),
    .wr_data  (cfg_wr_data),
    .base_ptr (base_ptr)
  );

  xw_walk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .base_ptr  (base_ptr),
    .ent_valid (mem_rd_rsp_valid),
    .ent_ptr   (mem_rd_rsp_data[VA_W-1:0]),
    .req_ready (req_ready),
    .rd_req    (mem_rd_req),
    .done      (rsp_valid),
    .lvl       (lvl),
    .tbl_ptr   (tbl_ptr),
    .va        (va),
    .res_ld    (res_ld),
    .res_fault (res_fault)
  );

  xw_fetch_addr u_fetch (
    .lvl        (lvl),
    .tbl_ptr    (tbl_ptr),
    .va         (va),
    .fetch_addr (mem_rd_addr)
  );

  xw_leaf_decode u_leaf (
    .entry     (mem_rd_rsp_data),
    .va        (va),
    .meta_addr (leaf_meta),
    .attr      (leaf_attr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      meta_q  <= '0;
      attr_q  <= '0;
    end else if (res_ld) begin
      fault_q <= res_fault;
      meta_q  <= res_fault ? '0 : leaf_meta;
      attr_q  <= res_fault ? '0 : leaf_attr;
    end
  end

  assign rsp_fault     = fault_q;
  assign rsp_meta_addr = meta_q;
  assign rsp_comp_mode = attr_q.comp;
  assign rsp_lossy     = attr_q.lossy;
  assign rsp_tile      = attr_q.tile;
  assign rsp_depth     = attr_q.depth;
  assign rsp_ycr       = attr_q.ycr;
  assign rsp_format    = attr_q.fmt;
endmodule

// File: rtl/xw_walk_chk.sv
module xw_walk_chk
  import xw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_rd_req,
  input logic [VA_W-1:0] mem_rd_addr,
  input logic            mem_rd_rsp_valid,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [VA_W-1:0] rsp_meta_addr,
  input logic [1:0]      rsp_tile,
  input logic [5:0]      rsp_format
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_q <= 1'b0;
    else if (mem_rd_req)     pend_q <= 1'b1;
    else if (mem_rd_rsp_valid) pend_q <= 1'b0;
  end

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !pend_q);

  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q || mem_rd_req || rsp_valid) |-> !req_ready);

  assert_fault_zeroed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_meta_addr == '0 && rsp_tile == '0 && rsp_format == '0));

  assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[ENT_SH-1:0] == '0));
endmodule

bind meta_xlate_walker xw_walk_chk chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_ready        (req_ready),
  .mem_rd_req       (mem_rd_req),
  .mem_rd_addr      (mem_rd_addr),
  .mem_rd_rsp_valid (mem_rd_rsp_valid),
  .rsp_valid        (rsp_valid),
  .rsp_fault        (rsp_fault),
  .rsp_meta_addr    (rsp_meta_addr),
  .rsp_tile         (rsp_tile),
  .rsp_format       (rsp_format)
);

// File: tb/meta_xlate_walker_tb.sv
module meta_xlate_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [15:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_addr;
  logic        mem_rd_req;
  logic [47:0] mem_rd_addr;
  logic        mem_rd_rsp_valid;
  logic [63:0] mem_rd_rsp_data;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [47:0] rsp_meta_addr;
  logic [1:0]  rsp_comp_mode;
  logic        rsp_lossy;
  logic [1:0]  rsp_tile;
  logic [2:0]  rsp_depth;
  logic        rsp_ycr;
  logic [5:0]  rsp_format;

  always #10 clk = ~clk;

  meta_xlate_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_meta_addr(rsp_meta_addr),
    .rsp_comp_mode(rsp_comp_mode), .rsp_lossy(rsp_lossy), .rsp_tile(rsp_tile),
    .rsp_depth(rsp_depth), .rsp_ycr(rsp_ycr), .rsp_format(rsp_format)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mem [logic [47:0]];
  int          lat = 1;
  int          pend = 0;
  logic [47:0] pend_addr;
  logic [47:0] flog [8];
  int          fcnt = 0;
  int          ovl = 0;

  logic        g_fault;
  logic [47:0] g_meta;
  logic [1:0]  g_comp, g_tile;
  logic        g_lossy, g_ycr;
  logic [2:0]  g_depth;
  logic [5:0]  g_fmt;

  // memory model: answers each read 'lat' cycles after it is seen
  initial begin
    mem_rd_rsp_valid = 1'b0;
    mem_rd_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rd_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rd_rsp_valid = 1'b1;
          mem_rd_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
        end
      end
      if (rst_n && mem_rd_req) begin
        if (pend > 0) ovl++;
        if (fcnt < 8) flog[fcnt] = mem_rd_addr;
        fcnt++;
        pend_addr = mem_rd_addr;
        pend = lat;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic set_base(input logic [47:0] b);
    cfg_wr(16'h4200, b[31:0]);
    cfg_wr(16'h4204, {16'h0, b[47:32]});
  endtask

  function automatic logic [63:0] mk_leaf(input logic [47:0] p, input logic [1:0] comp,
      input logic lossy, input logic [1:0] tile, input logic [2:0] depth,
      input logic ycr, input logic [5:0] fmt);
    logic [63:0] e;
    e = {16'h0, p[47:8], 8'h00};
    e[63:58] = fmt; e[57] = ycr; e[56:54] = depth; e[53:52] = tile;
    e[51:48] = 4'h5; e[7:4] = 4'hA; e[3] = lossy; e[2:1] = comp; e[0] = 1'b1;
    return e;
  endfunction

  function automatic logic [47:0] ea_top(input logic [47:0] b, input logic [47:0] a);
    return {b[47:15], a[47:36], 3'b000};
  endfunction
  function automatic logic [47:0] ea_mid(input logic [47:0] m, input logic [47:0] a);
    return {m[47:15], a[35:24], 3'b000};
  endfunction
  function automatic logic [47:0] ea_leaf(input logic [47:0] l, input logic [47:0] a);
    return {l[47:13], 2'b00, a[23:16], 3'b000};
  endfunction

  // bad_lvl: 2 top invalid, 1 middle invalid, 0 leaf invalid, 3 none
  task automatic build(input logic [47:0] b, input logic [47:0] a, input logic [47:0] m,
      input logic [47:0] l, input logic [63:0] leaf, input int bad_lvl);
    mem.delete();
    mem[ea_top(b, a)]  = {16'h0, m} | 64'h4020 | ((bad_lvl == 2) ? 64'h0 : 64'h1);
    mem[ea_mid(m, a)]  = {16'h0, l} | 64'h1008 | ((bad_lvl == 1) ? 64'h0 : 64'h1);
    mem[ea_leaf(l, a)] = (bad_lvl == 0) ? (leaf & ~64'h1) : leaf;
  endtask

  task automatic walk(input logic [47:0] a, input bit wr_new, input logic [47:0] nb,
                      input bit poke, input string tag);
    bit busy_ok = 1'b1;
    bit got = 1'b0;
    @(negedge clk);
    fcnt = 0; ovl = 0;
    chk({tag, " R9 ready before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a;
    if (wr_new) begin
      cfg_wr_en = 1'b1; cfg_wr_addr = 16'h4200; cfg_wr_data = nb[31:0];
    end
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1;
        g_fault = rsp_fault; g_meta = rsp_meta_addr; g_comp = rsp_comp_mode;
        g_lossy = rsp_lossy; g_tile = rsp_tile; g_depth = rsp_depth;
        g_ycr = rsp_ycr; g_fmt = rsp_format;
      end
      if (req_ready) busy_ok = 1'b0;
      if (i == 0) begin
        req_valid = poke;
        req_addr  = a ^ 48'h0011_0100_0000;
        if (wr_new) begin
          cfg_wr_addr = 16'h4204; cfg_wr_data = {16'h0, nb[47:32]};
        end else cfg_wr_en = 1'b0;
      end
      if (i == 1) begin
        req_valid = 1'b0; cfg_wr_en = 1'b0;
      end
    end
    chk({tag, " R9 response seen"}, 64'(got), 64'd1);
    chk({tag, " R9 ready low while busy"}, 64'(busy_ok), 64'd1);
    @(negedge clk);
    chk({tag, " R9 response one cycle"}, 64'(rsp_valid), 64'd0);
    chk({tag, " R9 ready after response"}, 64'(req_ready), 64'd1);
    chk({tag, " R8 no overlapping reads"}, 64'(ovl), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_rd_req", 64'(mem_rd_req), 64'd0);
  endtask

  task automatic t_translate(input logic [47:0] b, input logic [47:0] a,
      input logic [47:0] m, input logic [47:0] l, input logic [47:0] p,
      input logic [1:0] comp, input logic lossy, input logic [1:0] tile,
      input logic [2:0] depth, input logic ycr, input logic [5:0] fmt, input int lt);
    lat = lt;
    set_base(b);
    build(b, a, m, l, mk_leaf(p, comp, lossy, tile, depth, ycr, fmt), 3);
    walk(a, 1'b0, '0, 1'b0, "translate");
    chk("R8 three reads", 64'(fcnt), 64'd3);
    chk("R2 top fetch", 64'(flog[0]), 64'(ea_top(b, a)));
    chk("R3 middle fetch", 64'(flog[1]), 64'(ea_mid(m, a)));
    chk("R4 leaf fetch", 64'(flog[2]), 64'(ea_leaf(l, a)));
    chk("R7 no fault", 64'(g_fault), 64'd0);
    chk("R5 meta address", 64'(g_meta), 64'({p[47:8], a[15:8]}));
    chk("R6 comp", 64'(g_comp), 64'(comp));
    chk("R6 lossy", 64'(g_lossy), 64'(lossy));
    chk("R6 tile", 64'(g_tile), 64'(tile));
    chk("R6 depth", 64'(g_depth), 64'(depth));
    chk("R6 ycr", 64'(g_ycr), 64'(ycr));
    chk("R6 format", 64'(g_fmt), 64'(fmt));
  endtask

  task automatic t_fault(input int bad_lvl);
    logic [47:0] b = 48'h0000_0040_8000;
    logic [47:0] a = 48'h0123_4567_89AB;
    lat = 2;
    set_base(b);
    build(b, a, 48'h0000_1234_0000, 48'h0000_0055_6000,
          mk_leaf(48'h0000_00AB_CD00, 2'd3, 1'b1, 2'd1, 3'd5, 1'b1, 6'h0A), bad_lvl);
    walk(a, 1'b0, '0, 1'b0, "fault");
    chk("R7 reads stop at invalid level", 64'(fcnt), 64'(3 - bad_lvl));
    chk("R7 fault flag", 64'(g_fault), 64'd1);
    chk("R7 meta zero", 64'(g_meta), 64'd0);
    chk("R7 attrs zero", 64'({g_comp, g_lossy, g_tile, g_depth, g_ycr, g_fmt}), 64'd0);
  endtask

  task automatic t_rewrite();
    logic [47:0] b0 = 48'h0000_0010_0000;
    logic [47:0] b1 = 48'h0000_7777_8000;
    logic [47:0] a  = 48'h0ABC_DEF0_1234;
    lat = 1;
    set_base(b0);
    build(b0, a, 48'h0000_2000_8000, 48'h0000_3000_2000,
          mk_leaf(48'h0000_4000_0100, 2'd1, 1'b0, 2'd2, 3'd3, 1'b0, 6'h15), 3);
    walk(a, 1'b1, b1, 1'b0, "rewrite");
    chk("R10 walk used captured base", 64'(flog[0]), 64'(ea_top(b0, a)));
    chk("R10 walk completed", 64'(g_fault), 64'd0);
    walk(a, 1'b0, '0, 1'b0, "rewrite-next");
    chk("R10 next walk uses new base", 64'(flog[0]), 64'(ea_top(b1, a)));
  endtask

  task automatic t_busy();
    logic [47:0] b = 48'h0000_0100_0000;
    logic [47:0] a = 48'h0F0F_0F0F_0F0F;
    lat = 3;
    set_base(b);
    build(b, a, 48'h0000_0900_0000, 48'h0000_0A00_4000,
          mk_leaf(48'h0000_0B00_0200, 2'd2, 1'b1, 2'd3, 3'd7, 1'b1, 6'h3F), 3);
    walk(a, 1'b0, '0, 1'b1, "busy");
    chk("R9 dropped request adds no reads", 64'(fcnt), 64'd3);
    chk("R9 walk kept original address", 64'(flog[0]), 64'(ea_top(b, a)));
    repeat (4) @(negedge clk);
    chk("R9 no walk started later", 64'(fcnt), 64'd3);
  endtask

  task automatic t_offset();
    logic [47:0] b = 48'h0000_0020_8000;
    logic [47:0] a = 48'h0000_1000_0000;
    lat = 1;
    set_base(b);
    cfg_wr(16'h4208, 32'hFFFF_FFFF);
    cfg_wr(16'h4100, 32'h1234_5678);
    cfg_wr(16'h0200, 32'hDEAD_8000);
    build(b, a, 48'h0000_0300_0000, 48'h0000_0400_0000,
          mk_leaf(48'h0000_0500_0000, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 6'h01), 3);
    walk(a, 1'b0, '0, 1'b0, "offset");
    chk("R2 other offsets ignored", 64'(flog[0]), 64'(ea_top(b, a)));
    chk("R5 meta with zero low index", 64'(g_meta), 64'h0000_0500_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R9 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_translate(48'h0000_0001_8000, 48'h1234_5678_9ABC, 48'h0000_00A0_0000,
                48'h0000_00B0_6000, 48'h0000_00C0_0300,
                2'd1, 1'b1, 2'd1, 3'd5, 1'b0, 6'h0A, 1);
    t_translate(48'hFFFF_FFFF_8000, 48'hFFF0_00FF_FF00, 48'hFEDC_BA98_0000,
                48'hF123_4567_E000, 48'hEEEE_DDDD_CC00,
                2'd2, 1'b0, 2'd2, 3'd2, 1'b1, 6'h35, 3);
    t_fault(2);
    t_fault(1);
    t_fault(0);
    t_rewrite();
    t_busy();
    t_offset();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule